// File: doc/BRIEF.md
# Manchester Line Serialiser

This block takes 32-bit words from a valid/ready source and sends them out on a single wire as a Manchester-coded bit stream. Each data bit is split into two equal halves with a level change in the middle: a zero is sent as high then low, and a one as low then high. Bits leave least significant first.

Timing comes from an internal tick generator. A programmable integer divider makes one tick every `div_ratio` clocks, and a value of 0 counts as 1. Each half-bit lasts a fixed six ticks, so the bit rate is the clock frequency divided by twelve times the divider. The tick counter is held at zero while the serialiser is idle, so the first tick after a word is loaded always comes `div_ratio` clocks after the load edge.

When the last bit of a word finishes, the next word is taken in the same cycle if one is offered, and the stream continues with no gap. If no word is waiting, the line keeps its last level until one arrives. The output is a register and is low after reset.

Top module: `mtx_manchester_tx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `line_out` is 0 and `in_ready` is 1.
- R2: A half-bit lasts 6 ticks, and a tick comes every D clocks, where D is `div_ratio` or 1 when `div_ratio` is 0. The first half of a newly loaded word starts at the clock edge D cycles after the load edge.
- R3: A data bit of value 0 is sent with `line_out` at 1 for the first half and 0 for the second half.
- R4: A data bit of value 1 is sent with `line_out` at 0 for the first half and 1 for the second half.
- R5: Word bit 0 goes out first and bit 31 goes out last.
- R6: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. After that edge, `in_ready` stays 0 until the tick that ends the word's final bit.
- R7: A word offered while the current one is being sent starts right after the current word's final half ends, with no idle time on the line.
- R8: While no word is in flight, `line_out` keeps its level and does not change.
- R9: A reset in the middle of a word drops that word, forces `line_out` to 0 and raises `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| div_ratio | input | 16 | Clocks per tick; 0 is treated as 1 |
| in_data | input | 32 | Word to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | A word can be taken this cycle |
| line_out | output | 1 | Manchester-coded line |

## Verification
If the phase counter is wrong, the line changes level at the wrong time or in the wrong direction. This shows up at the port within one half-bit, which is 6·D clocks. If the shift register or the bit counter is wrong, the bit order goes wrong, or the word boundary moves and `in_ready` rises early or late. This shows up no later than the end of the word. The bench samples each half in its middle, with the timing worked out from the load edge, so any of these faults causes a level mismatch.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
   function automatic int clog2_min1(input int val);
      int r;
      r = 1;
      while ((1 << r) < val) r++;
      return r;
   endfunction
endpackage

// File: rtl/mtx_tick_gen.sv
module mtx_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] div_ratio,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;

   generate
      if (DIV_W == 1) begin : g_narrow
         assign last = '0;
      end else begin : g_wide
         assign last = (div_ratio == '0) ? '0 : div_ratio - 1'b1;
      end
   endgenerate

   assign tick = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (rst || !run || tick) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mtx_word_shifter.sv
module mtx_word_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              bit_done,
   output logic              cur_bit,
   output logic              busy
);
   localparam int CNT_W = mtx_pkg::clog2_min1(WORD_W + 1);

   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  bits_left;
   logic              load;

   assign in_ready = (bits_left == '0) ||
                     ((bits_left == CNT_W'(1)) && bit_done);
   assign load     = in_valid && in_ready;
   assign cur_bit  = sreg[0];
   assign busy     = (bits_left != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg      <= '0;
         bits_left <= '0;
      end else if (load) begin
         sreg      <= in_data;
         bits_left <= CNT_W'(WORD_W);
      end else if (bit_done) begin
         sreg      <= sreg >> 1;
         bits_left <= bits_left - 1'b1;
      end
   end
endmodule

// File: rtl/mtx_phase_enc.sv
module mtx_phase_enc #(
   parameter int HALF_TICKS = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic cur_bit,
   output logic bit_done,
   output logic line_out
);
   localparam int BIT_TICKS = 2 * HALF_TICKS;
   localparam int PH_W      = mtx_pkg::clog2_min1(BIT_TICKS);

   logic [PH_W-1:0] ph;
   logic            at_last;

   assign at_last  = (ph == PH_W'(BIT_TICKS - 1));
   assign bit_done = tick && at_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph       <= '0;
         line_out <= 1'b0;
      end else if (tick) begin
         ph <= at_last ? '0 : ph + 1'b1;
         if (ph == '0)                     line_out <= ~cur_bit;
         else if (ph == PH_W'(HALF_TICKS)) line_out <= cur_bit;
      end
   end
endmodule

// File: rtl/mtx_manchester_tx.sv
module mtx_manchester_tx #(
   parameter int WORD_W     = 32,
   parameter int HALF_TICKS = 6,
   parameter int DIV_W      = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  div_ratio,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              line_out
);
   generate
      if (WORD_W < 2)     begin : g_bad_word $error("WORD_W must be at least 2"); end
      if (HALF_TICKS < 1) begin : g_bad_half $error("HALF_TICKS must be at least 1"); end
      if (DIV_W < 1)      begin : g_bad_div  $error("DIV_W must be at least 1"); end
   endgenerate

   logic tick, busy, cur_bit, bit_done;

   mtx_tick_gen #(.DIV_W(DIV_W)) i_tick (
      .clk(clk), .rst(rst), .run(busy), .div_ratio(div_ratio), .tick(tick)
   );

   mtx_word_shifter #(.WORD_W(WORD_W)) i_shift (
      .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .bit_done(bit_done), .cur_bit(cur_bit), .busy(busy)
   );

   mtx_phase_enc #(.HALF_TICKS(HALF_TICKS)) i_phase (
      .clk(clk), .rst(rst), .tick(tick), .cur_bit(cur_bit),
      .bit_done(bit_done), .line_out(line_out)
   );
endmodule

// File: rtl/mtx_manchester_tx_chk.sv
module mtx_manchester_tx_chk (
   input logic clk,
   input logic rst,
   input logic in_valid,
   input logic in_ready,
   input logic line_out
);
   AST_RST_LINE_LOW: assert property (@(posedge clk) rst |=> (!line_out && in_ready)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      in_ready |=> $stable(line_out)); // R8
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready); // R6
   AST_EDGE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
      !$stable(line_out) |-> !$past(in_ready)); // R2
endmodule

bind mtx_manchester_tx mtx_manchester_tx_chk i_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .line_out(line_out)
);

// File: tb/test_mtx_manchester_tx.sv
module test_mtx_manchester_tx;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] div_ratio = 16'd1;
   logic [31:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready, line_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q[$];
   bit mon_busy = 1'b0;

   always #10 clk = ~clk;

   mtx_manchester_tx i_mtx_manchester_tx (
      .clk(clk), .rst(rst), .div_ratio(div_ratio), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .line_out(line_out)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // driver: offer one word and push it to the scoreboard
   task automatic send(input logic [31:0] w);
      @(posedge clk); #1;
      in_data  = w;
      in_valid = 1'b1;
      exp_q.push_back(w);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   // monitor: each accepted word is checked half by half in mid-half
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && in_valid && in_ready) begin
            logic [31:0] w;
            int d;
            bit abort;
            mon_busy = 1'b1;
            abort = 1'b0;
            w = exp_q.pop_front();
            d = (div_ratio == 0) ? 1 : int'(div_ratio);
            for (int k = 0; k < 64 && !abort; k++) begin
               for (int j = 0; j < ((k == 0) ? 4 * d : 6 * d); j++) begin
                  @(negedge clk);
                  if (rst) abort = 1'b1;
                  if (abort) break;
               end
               if (!abort) begin
                  logic b, e;
                  b = w[k / 2];
                  e = (k % 2 == 1) ? b : ~b;
                  if (b) check(line_out == e, "R4 (R2 R5 R7)", 32'(line_out), 32'(e));
                  else   check(line_out == e, "R3 (R2 R5 R7)", 32'(line_out), 32'(e));
               end
            end
            mon_busy = 1'b0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   task automatic drain();
      @(negedge clk);
      while (mon_busy || exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic idle_hold(input logic lvl);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check(line_out == lvl, "R8", 32'(line_out), 32'(lvl));
      end
      check(in_ready == 1'b1, "R6 ready when idle", 32'(in_ready), 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(line_out == 1'b0, "R1 line", 32'(line_out), 32'd0);
      check(in_ready == 1'b1, "R1 ready", 32'(in_ready), 32'd1);
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      check(line_out == 1'b0, "R1 after release", 32'(line_out), 32'd0);
      idle_hold(1'b0);

      // divider 1, single word, then two back-to-back words (R7)
      send(32'hA5A5_0F0F);
      repeat (20) @(negedge clk);
      check(in_ready == 1'b0, "R6 ready low mid-word", 32'(in_ready), 32'd0);
      drain();
      idle_hold(1'b1);                // bit 31 of A5A50F0F is 1
      send(32'h0000_FFFF);
      send(32'hFFFF_0001);
      drain();
      idle_hold(1'b1);

      // divider 3 (R2)
      div_ratio = 16'd3;
      send(32'h8000_0001);
      send(32'h1234_5678);
      drain();
      idle_hold(1'b0);

      // divider 0 behaves as 1 (R2)
      div_ratio = 16'd0;
      send(32'hDEAD_BEEF);
      drain();
      idle_hold(1'b1);

      // reset in mid-word (R9)
      div_ratio = 16'd2;
      send(32'h0F0F_F0F0);
      repeat (100) @(negedge clk);
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      check(line_out == 1'b0, "R9 line", 32'(line_out), 32'd0);
      check(in_ready == 1'b1, "R9 ready", 32'(in_ready), 32'd1);
      repeat (20) @(negedge clk);
      check(line_out == 1'b0, "R9 stays low", 32'(line_out), 32'd0);
      wait (!mon_busy);
      send(32'h0000_0003);
      drain();
      summary();
   end
endmodule